// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block sits behind the write port of a NOR-style flash controller. It watches bus write cycles (an address and a data word per cycle) and recognises the multi-cycle command sequences that the array logic acts on. These are reset, autoselect, word program, chip erase, sector erase and a two-cycle program used in fast mode. When a sequence completes, the block raises a one-cycle command pulse that carries an operation code and the captured address and data. Any cycle that does not fit the sequence in progress sends it back to read mode without a pulse.

Standard commands open with two unlock cycles. After the second unlock pair of an erase, a sector-erase write opens an accumulation window: further sector-erase writes inside it add sectors and restart it. Fast mode lets the host program with two cycles per word. While the array reports an embedded operation in progress, the block acts on reset and suspend writes and ignores all other writes.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset, `cmd_valid_o`, `fast_mode_o` and `erase_window_o` are low and the decoder is in read mode.
- R2: Outside fast mode and outside the data cycle of a program, a write whose data low byte is F0h at any address gives a reset pulse (op 0). This pulse is seen in the cycle after the write edge, lasts one cycle and carries the write address and data. The sequence then restarts.
- R3: Word program: AAh@555h, 55h@2AAh, A0h@555h, then any address and data. This gives a program pulse (op 2) with that address and data one cycle after the fourth write, and no pulse before it. Only address bits [10:0] and data bits [7:0] are decoded.
- R4: AAh@555h, 55h@2AAh, 90h@555h gives an autoselect pulse (op 1).
- R5: AAh@555h, 55h@2AAh, 80h@555h, AAh@555h, 55h@2AAh, 10h@555h gives a chip-erase pulse (op 3).
- R6: The same first five cycles followed by 30h at any address give a sector-erase pulse (op 4) carrying that address. `erase_window_o` then stays high for ERASE_WIN cycles after the write edge.
- R7: While `erase_window_o` is high, a 30h write gives another sector-erase pulse and restarts the window. Any other write closes the window. A 30h write after the window has closed gives no pulse.
- R8: A write that fits no sequence gives no pulse and returns to read mode, so the cycles of a broken sequence that follow it give no pulse.
- R9: AAh@555h, 55h@2AAh, 20h@555h raises `fast_mode_o` without a pulse. In fast mode, A0h at any address followed by any address and data gives a program pulse (op 2). Other writes leave fast mode set.
- R10: In fast mode, 90h at any address followed by F0h at any address clears `fast_mode_o` without a pulse. 90h followed by anything else stays in fast mode.
- R11: While `busy_i` is high, F0h gives a reset pulse and returns to the start of the current mode, and B0h gives a suspend pulse (op 5). Every other write is ignored and leaves the sequence progress unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_valid_i | input | 1 | A bus write cycle is present this clock |
| wr_addr_i | input | ADDR_W | Write address |
| wr_data_i | input | DATA_W | Write data |
| busy_i | input | 1 | Embedded operation in progress |
| cmd_valid_o | output | 1 | One-cycle command pulse |
| cmd_op_o | output | 3 | Operation code: 0 reset, 1 autoselect, 2 program, 3 chip erase, 4 sector erase, 5 suspend |
| cmd_addr_o | output | ADDR_W | Address captured with the command |
| cmd_data_o | output | DATA_W | Data captured with the command |
| fast_mode_o | output | 1 | Fast mode active |
| erase_window_o | output | 1 | Sector-erase accumulation window open |

## Verification
The assertions check on every cycle that:
- the erase window only opens together with a sector-erase pulse, and the window counter only restarts on a load;
- no pulse appears without a write in the cycle before;
- a busy write yields only reset or suspend pulses;
- fast mode rises silently and falls only after an F0h write.

Only the bench scenarios can show the sequence content and the window timing. These are the exact cycle counts of each command, the last cycle at which an extra sector is still accepted, the progress kept through ignored busy writes, and recovery after a corrupted sequence.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  typedef enum logic [2:0] {
    OP_RESET   = 3'd0,
    OP_AUTOSEL = 3'd1,
    OP_PROGRAM = 3'd2,
    OP_CHIP    = 3'd3,
    OP_SECTOR  = 3'd4,
    OP_SUSPEND = 3'd5
  } cmd_op_e;

  typedef enum logic [3:0] {
    S_IDLE, S_UL1, S_UL2, S_PROG, S_ESET, S_EUL1, S_EUL2, S_WIN,
    S_FIDLE, S_FPROG, S_FEXIT
  } seq_state_e;

  typedef struct packed {
    logic a555;
    logic a2aa;
    logic d_aa;
    logic d_55;
    logic d_a0;
    logic d_80;
    logic d_90;
    logic d_20;
    logic d_10;
    logic d_30;
    logic d_f0;
    logic d_b0;
  } match_t;

endpackage

// File: rtl/flash_cmd_match.sv
module flash_cmd_match
  import flash_cmd_pkg::*;
#(
  parameter int KEY_W = 11
) (
  input  logic [KEY_W-1:0] key_addr_i,
  input  logic [7:0]       code_i,
  output match_t           m_o
);
  localparam logic [KEY_W-1:0] KeyA = KEY_W'(16'h0555);
  localparam logic [KEY_W-1:0] KeyB = KEY_W'(16'h02AA);

  always_comb begin
    m_o.a555 = (key_addr_i == KeyA);
    m_o.a2aa = (key_addr_i == KeyB);
    m_o.d_aa = (code_i == 8'hAA);
    m_o.d_55 = (code_i == 8'h55);
    m_o.d_a0 = (code_i == 8'hA0);
    m_o.d_80 = (code_i == 8'h80);
    m_o.d_90 = (code_i == 8'h90);
    m_o.d_20 = (code_i == 8'h20);
    m_o.d_10 = (code_i == 8'h10);
    m_o.d_30 = (code_i == 8'h30);
    m_o.d_f0 = (code_i == 8'hF0);
    m_o.d_b0 = (code_i == 8'hB0);
  end
endmodule

// File: rtl/flash_erase_timer.sv
module flash_erase_timer #(
  parameter int ERASE_WIN = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic clear_i,
  output logic open_o
);
  localparam int CNT_W = $clog2(ERASE_WIN + 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (load_i)           cnt_q <= CNT_W'(ERASE_WIN);
    else if (clear_i)          cnt_q <= '0;
    else if (cnt_q != '0)      cnt_q <= cnt_q - 1'b1;
  end

  assign open_o = (cnt_q != '0);

  a_r7_reopen_needs_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(open_o) |-> $past(load_i));
endmodule

// File: rtl/flash_seq_fsm.sv
module flash_seq_fsm
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W = 23,
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_valid_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              busy_i,
  input  match_t            m_i,
  input  logic              win_open_i,
  output logic              win_load_o,
  output logic              win_clear_o,
  output logic              cmd_valid_o,
  output cmd_op_e           cmd_op_o,
  output logic [ADDR_W-1:0] cmd_addr_o,
  output logic [DATA_W-1:0] cmd_data_o,
  output logic              fast_mode_o
);
  seq_state_e st_q, st_d, eff;
  logic       emit;
  cmd_op_e    op;
  logic       fast;

  assign fast = (st_q == S_FIDLE) || (st_q == S_FPROG) || (st_q == S_FEXIT);
  // an expired window behaves as read mode
  assign eff  = (st_q == S_WIN && !win_open_i) ? S_IDLE : st_q;

  always_comb begin
    st_d        = st_q;
    emit        = 1'b0;
    op          = OP_RESET;
    win_load_o  = 1'b0;
    win_clear_o = 1'b0;
    if (!wr_valid_i) begin
      st_d = eff;
    end else if (busy_i) begin
      if (m_i.d_f0) begin
        emit        = 1'b1;
        win_clear_o = 1'b1;
        st_d        = fast ? S_FIDLE : S_IDLE;
      end else if (m_i.d_b0) begin
        emit = 1'b1;
        op   = OP_SUSPEND;
      end
    end else if (!fast && eff != S_PROG && m_i.d_f0) begin
      emit        = 1'b1;
      win_clear_o = 1'b1;
      st_d        = S_IDLE;
    end else begin
      win_clear_o = 1'b1;
      st_d        = S_IDLE;
      unique case (eff)
        S_IDLE: if (m_i.a555 && m_i.d_aa) st_d = S_UL1;
        S_UL1:  if (m_i.a2aa && m_i.d_55) st_d = S_UL2;
        S_UL2: if (m_i.a555) begin
          if (m_i.d_a0)      st_d = S_PROG;
          else if (m_i.d_80) st_d = S_ESET;
          else if (m_i.d_20) st_d = S_FIDLE;
          else if (m_i.d_90) begin emit = 1'b1; op = OP_AUTOSEL; end
        end
        S_PROG: begin emit = 1'b1; op = OP_PROGRAM; end
        S_ESET: if (m_i.a555 && m_i.d_aa) st_d = S_EUL1;
        S_EUL1: if (m_i.a2aa && m_i.d_55) st_d = S_EUL2;
        S_EUL2, S_WIN: begin
          if (eff == S_EUL2 && m_i.a555 && m_i.d_10) begin
            emit = 1'b1;
            op   = OP_CHIP;
          end else if (m_i.d_30) begin
            emit        = 1'b1;
            op          = OP_SECTOR;
            win_load_o  = 1'b1;
            win_clear_o = 1'b0;
            st_d        = S_WIN;
          end
        end
        S_FIDLE: st_d = m_i.d_a0 ? S_FPROG : (m_i.d_90 ? S_FEXIT : S_FIDLE);
        S_FPROG: begin emit = 1'b1; op = OP_PROGRAM; st_d = S_FIDLE; end
        S_FEXIT: st_d = m_i.d_f0 ? S_IDLE : S_FIDLE;
        default: st_d = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= S_IDLE;
      cmd_valid_o <= 1'b0;
      cmd_op_o    <= OP_RESET;
      cmd_addr_o  <= '0;
      cmd_data_o  <= '0;
    end else begin
      st_q        <= st_d;
      cmd_valid_o <= emit;
      if (emit) begin
        cmd_op_o   <= op;
        cmd_addr_o <= wr_addr_i;
        cmd_data_o <= wr_data_i;
      end
    end
  end

  assign fast_mode_o = fast;

  a_r11_busy_filter: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_i && busy_i) |=> (!cmd_valid_o || cmd_op_o == OP_RESET || cmd_op_o == OP_SUSPEND));
  a_r3_pulse_needs_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |-> $past(wr_valid_i));
  a_r9_fast_entry_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fast_mode_o) |-> !cmd_valid_o);
  a_r10_fast_exit_on_f0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(fast_mode_o) |-> $past(wr_valid_i && m_i.d_f0));
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W    = 23,
  parameter int DATA_W    = 16,
  parameter int KEY_W     = 11,
  parameter int ERASE_WIN = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_valid_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              busy_i,
  output logic              cmd_valid_o,
  output logic [2:0]        cmd_op_o,
  output logic [ADDR_W-1:0] cmd_addr_o,
  output logic [DATA_W-1:0] cmd_data_o,
  output logic              fast_mode_o,
  output logic              erase_window_o
);
  match_t  m;
  logic    win_load, win_clear;
  cmd_op_e op;

  flash_cmd_match #(.KEY_W(KEY_W)) u_match (
    .key_addr_i (wr_addr_i[KEY_W-1:0]),
    .code_i     (wr_data_i[7:0]),
    .m_o        (m)
  );

  flash_erase_timer #(.ERASE_WIN(ERASE_WIN)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (win_load),
    .clear_i (win_clear),
    .open_o  (erase_window_o)
  );

  flash_seq_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_valid_i  (wr_valid_i),
    .wr_addr_i   (wr_addr_i),
    .wr_data_i   (wr_data_i),
    .busy_i      (busy_i),
    .m_i         (m),
    .win_open_i  (erase_window_o),
    .win_load_o  (win_load),
    .win_clear_o (win_clear),
    .cmd_valid_o (cmd_valid_o),
    .cmd_op_o    (op),
    .cmd_addr_o  (cmd_addr_o),
    .cmd_data_o  (cmd_data_o),
    .fast_mode_o (fast_mode_o)
  );

  assign cmd_op_o = op;

  a_r6_window_opens_with_sector: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(erase_window_o) |-> (cmd_valid_o && cmd_op_o == OP_SECTOR));
endmodule

// File: tb/flash_cmd_decoder_test.sv
`timescale 1ns/1ps
module flash_cmd_decoder_test;
  localparam int AW = 23, DW = 16, WIN = 12;

  logic          clk = 1'b0, rst_n = 1'b0;
  logic          wr_valid = 1'b0, busy = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic          cmd_valid, fast_mode, erase_window;
  logic [2:0]    cmd_op;
  logic [AW-1:0] cmd_addr;
  logic [DW-1:0] cmd_data;

  int n_tests = 0, n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  flash_cmd_decoder #(.ADDR_W(AW), .DATA_W(DW), .KEY_W(11), .ERASE_WIN(WIN)) uut (
    .clk_i(clk), .rst_ni(rst_n), .wr_valid_i(wr_valid), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .busy_i(busy), .cmd_valid_o(cmd_valid), .cmd_op_o(cmd_op),
    .cmd_addr_o(cmd_addr), .cmd_data_o(cmd_data), .fast_mode_o(fast_mode),
    .erase_window_o(erase_window));

  // reference model built from the requirements
  int ms = 0, mw = 0, eop = 0;
  bit ev = 1'b0;
  logic [AW-1:0] ea;
  logic [DW-1:0] ed;

  task automatic model_tick();
    if (mw > 0) mw--;
  endtask

  task automatic model_write(logic [AW-1:0] a, logic [DW-1:0] d, bit b);
    logic [10:0] k = a[10:0];
    logic [7:0]  c = d[7:0];
    int  eff = (ms == 7 && mw == 0) ? 0 : ms;
    bit  fst = (ms >= 8), ld = 1'b0, cl = 1'b0;
    ev = 1'b0;
    if (b) begin
      if (c == 8'hF0) begin ev = 1; eop = 0; cl = 1; ms = fst ? 8 : 0; end
      else if (c == 8'hB0) begin ev = 1; eop = 5; end
    end else if (!fst && eff != 3 && c == 8'hF0) begin
      ev = 1; eop = 0; cl = 1; ms = 0;
    end else begin
      cl = 1; ms = 0;
      case (eff)
        0: if (k == 11'h555 && c == 8'hAA) ms = 1;
        1: if (k == 11'h2AA && c == 8'h55) ms = 2;
        2: if (k == 11'h555) begin
             if (c == 8'hA0) ms = 3;
             else if (c == 8'h80) ms = 4;
             else if (c == 8'h20) ms = 8;
             else if (c == 8'h90) begin ev = 1; eop = 1; end
           end
        3: begin ev = 1; eop = 2; end
        4: if (k == 11'h555 && c == 8'hAA) ms = 5;
        5: if (k == 11'h2AA && c == 8'h55) ms = 6;
        6, 7: begin
             if (eff == 6 && k == 11'h555 && c == 8'h10) begin ev = 1; eop = 3; end
             else if (c == 8'h30) begin ev = 1; eop = 4; ld = 1; cl = 0; ms = 7; end
           end
        8: ms = (c == 8'hA0) ? 9 : ((c == 8'h90) ? 10 : 8);
        9: begin ev = 1; eop = 2; ms = 8; end
        10: ms = (c == 8'hF0) ? 0 : 8;
        default: ms = 0;
      endcase
    end
    if (ev) begin ea = a; ed = d; end
    if (ld) mw = WIN;
    else if (cl) mw = 0;
    else if (mw > 0) mw--;
  endtask

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic cmp_model(string tag);
    chk(tag, 32'(cmd_valid), 32'(ev));
    if (ev) begin
      chk(tag, 32'(cmd_op), 32'(eop));
      chk(tag, 32'(cmd_addr), 32'(ea));
      chk(tag, 32'(cmd_data), 32'(ed));
    end
    chk(tag, 32'(fast_mode), 32'(ms >= 8));
    chk(tag, 32'(erase_window), 32'(mw != 0));
  endtask

  task automatic wr(logic [AW-1:0] a, logic [DW-1:0] d, bit b, string tag);
    @(negedge clk);
    model_tick();
    wr_valid = 1'b1; wr_addr = a; wr_data = d; busy = b;
    @(posedge clk);
    model_write(a, d, b);
    @(negedge clk);
    wr_valid = 1'b0; busy = 1'b0;
    cmp_model(tag);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      model_tick();
      ev = 1'b0;
    end
  endtask

  function automatic logic [AW-1:0] ka(logic [10:0] k);
    return {12'($urandom), k};
  endfunction

  function automatic logic [DW-1:0] kd(logic [7:0] c);
    return {8'($urandom), c};
  endfunction

  task automatic unlock(string tag);
    wr(ka(11'h555), kd(8'hAA), 0, tag);
    wr(ka(11'h2AA), kd(8'h55), 0, tag);
  endtask

  // random stream: each cycle corrupted with small probability
  task automatic rw(logic [AW-1:0] a, logic [DW-1:0] d);
    logic [DW-1:0] dd = d;
    bit b = ($urandom % 12) == 0;
    if (($urandom % 10) == 0) dd = DW'($urandom);
    wr(a, dd, b, "R8 random stream");
  endtask

  task automatic rand_cmd();
    int kind = $urandom % 9;
    case (kind)
      0: rw(AW'($urandom), kd(8'hF0));
      1, 2, 3, 4, 5: begin
        rw(ka(11'h555), kd(8'hAA)); rw(ka(11'h2AA), kd(8'h55));
        case (kind)
          1: rw(ka(11'h555), kd(8'h90));
          2: begin rw(ka(11'h555), kd(8'hA0)); rw(AW'($urandom), DW'($urandom)); end
          5: rw(ka(11'h555), kd(8'h20));
          default: begin
            rw(ka(11'h555), kd(8'h80));
            rw(ka(11'h555), kd(8'hAA)); rw(ka(11'h2AA), kd(8'h55));
            if (kind == 3) rw(ka(11'h555), kd(8'h10));
            else for (int i = 0; i <= int'($urandom % 3); i++) rw(AW'($urandom), kd(8'h30));
          end
        endcase
      end
      6: begin rw(AW'($urandom), kd(8'hA0)); rw(AW'($urandom), DW'($urandom)); end
      7: begin rw(AW'($urandom), kd(8'h90)); rw(AW'($urandom), kd(8'hF0)); end
      default: begin
        rw(AW'($urandom), DW'($urandom));
        if (($urandom % 4) == 0) idle(int'($urandom % (WIN + 2)));
      end
    endcase
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0013));
    repeat (3) @(negedge clk);
    chk("R1 valid after reset", 32'(cmd_valid), 0);
    chk("R1 fast after reset", 32'(fast_mode), 0);
    chk("R1 window after reset", 32'(erase_window), 0);
    rst_n = 1'b1;

    // R3 word program
    unlock("R3 no early pulse");
    wr(ka(11'h555), kd(8'hA0), 0, "R3 no early pulse");
    wr(23'h12345, 16'hBEEF, 0, "R3 program");
    chk("R3 op", 32'(cmd_op), 2);
    chk("R3 addr", 32'(cmd_addr), 32'h12345);
    chk("R3 data", 32'(cmd_data), 32'hBEEF);
    idle(1);
    chk("R2 pulse is one cycle", 32'(cmd_valid), 0);

    // R2 reset mid-sequence restarts
    unlock("R2 setup");
    wr(23'h7F0F0, 16'h00F0, 0, "R2 reset");
    chk("R2 reset pulse", 32'(cmd_valid), 1);
    chk("R2 reset op", 32'(cmd_op), 0);
    chk("R2 reset addr", 32'(cmd_addr), 32'h7F0F0);
    wr(ka(11'h555), kd(8'hA0), 0, "R2 restarted");
    wr(23'h00001, 16'h1111, 0, "R2 restarted");
    chk("R2 no program after reset", 32'(cmd_valid), 0);

    // R4 autoselect
    unlock("R4 setup");
    wr(ka(11'h555), kd(8'h90), 0, "R4 autoselect");
    chk("R4 op", 32'(cmd_op), 1);

    // R5 chip erase
    unlock("R5 setup");
    wr(ka(11'h555), kd(8'h80), 0, "R5 setup");
    unlock("R5 setup");
    wr(ka(11'h555), kd(8'h10), 0, "R5 chip erase");
    chk("R5 op", 32'(cmd_op), 3);
    chk("R5 valid", 32'(cmd_valid), 1);

    // R6 sector erase and window length
    unlock("R6 setup");
    wr(ka(11'h555), kd(8'h80), 0, "R6 setup");
    unlock("R6 setup");
    wr(23'h40000, kd(8'h30), 0, "R6 sector");
    chk("R6 op", 32'(cmd_op), 4);
    chk("R6 addr", 32'(cmd_addr), 32'h40000);
    idle(WIN - 1);
    chk("R6 window open at last cycle", 32'(erase_window), 1);
    idle(1);
    chk("R6 window closed", 32'(erase_window), 0);
    wr(23'h50000, kd(8'h30), 0, "R7 late sector");
    chk("R7 late sector ignored", 32'(cmd_valid), 0);

    // R7 accept at last open cycle, restart, close on other write
    unlock("R7 setup");
    wr(ka(11'h555), kd(8'h80), 0, "R7 setup");
    unlock("R7 setup");
    wr(23'h10000, kd(8'h30), 0, "R7 first sector");
    idle(WIN - 2);
    wr(23'h20000, kd(8'h30), 0, "R7 extra sector");
    chk("R7 extra sector op", 32'(cmd_op), 4);
    chk("R7 window restarted", 32'(erase_window), 1);
    wr(23'h30000, kd(8'h55), 0, "R7 close");
    chk("R7 window closed by other write", 32'(erase_window), 0);
    wr(23'h30000, kd(8'h30), 0, "R7 after close");
    chk("R7 no sector after close", 32'(cmd_valid), 0);

    // R8 illegal cycle
    wr(ka(11'h555), kd(8'hAA), 0, "R8 setup");
    wr(ka(11'h555), kd(8'h55), 0, "R8 wrong addr");
    wr(ka(11'h555), kd(8'hA0), 0, "R8 broken");
    wr(23'h00077, 16'h7777, 0, "R8 broken");
    chk("R8 no program", 32'(cmd_valid), 0);

    // R9 fast mode
    unlock("R9 setup");
    wr(ka(11'h555), kd(8'h20), 0, "R9 enter");
    chk("R9 fast set", 32'(fast_mode), 1);
    chk("R9 no pulse on entry", 32'(cmd_valid), 0);
    wr(AW'($urandom), kd(8'h3C), 0, "R9 junk");
    chk("R9 stays fast", 32'(fast_mode), 1);
    wr(AW'($urandom), kd(8'hA0), 0, "R9 fast setup");
    wr(23'h0ABCD, 16'h00F0, 0, "R9 fast program");
    chk("R9 op", 32'(cmd_op), 2);
    chk("R9 data", 32'(cmd_data), 32'h00F0);

    // R10 fast exit
    wr(AW'($urandom), kd(8'h90), 0, "R10 exit");
    wr(AW'($urandom), kd(8'h12), 0, "R10 bad exit");
    chk("R10 still fast", 32'(fast_mode), 1);
    wr(AW'($urandom), kd(8'h90), 0, "R10 exit");
    wr(AW'($urandom), kd(8'hF0), 0, "R10 exit");
    chk("R10 fast cleared", 32'(fast_mode), 0);
    chk("R10 no pulse", 32'(cmd_valid), 0);

    // R11 busy filtering
    unlock("R11 setup");
    wr(ka(11'h555), kd(8'hA0), 1, "R11 ignored");
    chk("R11 ignored write", 32'(cmd_valid), 0);
    wr(AW'($urandom), kd(8'hB0), 1, "R11 suspend");
    chk("R11 suspend op", 32'(cmd_op), 5);
    wr(ka(11'h555), kd(8'hA0), 0, "R11 progress kept");
    wr(23'h00042, 16'h4242, 0, "R11 progress kept");
    chk("R11 program after busy", 32'(cmd_op), 2);
    unlock("R11 setup");
    wr(AW'($urandom), kd(8'hF0), 1, "R11 busy reset");
    chk("R11 reset op", 32'(cmd_op), 0);

    for (int i = 0; i < 250; i++) rand_cmd();

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule